// File: doc/BRIEF.md
# Plug-in Acquisition Module Bus Slave

This block is the logic-side slave of a plug-in analog acquisition module on a 16-bit carrier bus. The carrier raises one of two select strobes, either the I/O-space select or the ID-space select, together with a word address, a write flag and write data. The block decodes the access and sends it to one of four targets. The targets are a small read/write control register, a write-only strobe that starts a conversion, a read-only port that returns the converter result, and a fixed identification image. The converter result comes in on a plain 16-bit parallel input.

The block reports the end of an access with a single-cycle acknowledge. Read data is valid only in that cycle. The decode looks only at the upper address bits, so each I/O target is reachable at eight consecutive word addresses. Address ranges with no target never produce an acknowledge, and the carrier treats that silence as a bus error. The carrier holds its select until it sees the acknowledge, or until it gives up. It then drops the select for at least one cycle before starting the next access.

Top module: `ipm_bus_slave`

## Requirements
- R1: After synchronous reset, `ack`, `conv_pulse` and `rdata` are 0, and the control fields `trig_ctl` and `mode` are 0.
- R2: In I/O space, word addresses 0 to 7 all reach the same control register. A read returns `trig_ctl` on bit 15 and `mode` on bits 9:8. All other bits read 0. A write stores bit 15 and bits 9:8 and drops the rest.
- R3: A control-register read acknowledges in the first cycle after the edge that samples the select (zero wait states). A control-register write acknowledges one cycle later (one wait state), and the register takes the new value at the same edge that raises the acknowledge.
- R4: An I/O write to word addresses 8 to 15 acknowledges with zero wait states. `conv_pulse` is high for exactly the acknowledge cycle. The write data has no effect on the control register.
- R5: An I/O read of word addresses 16 to 23 acknowledges with zero wait states. It returns the value of `adc_data` at the edge that samples the select.
- R6: I/O word addresses 24 to 63 never acknowledge and cause no side effect. This covers the unused region, the reserved region at 32 to 39, and the unused region above it.
- R7: A read of the convert region and a write of the ADC region never acknowledge and cause no side effect.
- R8: An ID-space read of word index i (byte offset 2i+1) acknowledges with zero wait states and returns the image byte on bits 7:0, with bits 15:8 zero. Indexes 0 to 11 hold 49 50 41 43 A3 32 00 00 00 00 0C 2E (hex). Indexes 12 to 31 return 00. Address bit 5 is ignored in ID space.
- R9: ID-space writes never acknowledge and cause no side effect.
- R10: Each access gives at most one acknowledge, one cycle long. A new access starts only after both selects have been seen low.
- R11: When both selects are high, the access is decoded as an I/O-space access.
- R12: `rdata` is 0 in every cycle in which `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | I/O-space select, active high |
| id_sel | input | 1 | ID-space select, active high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Word address (byte address bits 6:1) |
| wdata | input | 16 | Write data |
| adc_data | input | 16 | Parallel converter result |
| rdata | output | 16 | Read data, valid with ack |
| ack | output | 1 | Single-cycle access acknowledge |
| conv_pulse | output | 1 | Single-cycle convert start |
| trig_ctl | output | 1 | Conversion-trigger control bit |
| mode | output | 2 | Acquisition mode field |

## Verification
The hardest condition to reach from the ports is proving that an access which is never acknowledged leaves no trace. Examples are a write to the reserved region, a write to the ADC port, and an ID-space write. None of these shows up on the outputs directly. The stimulus therefore follows each silent access with a control-register read and tracks `conv_pulse` over the whole window. Random sequences also mix aliased control addresses and overlapping selects, so each write is read back through a different alias of the same register.

// File: rtl/ipm_pkg.sv
package ipm_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL_RD,
    ACC_CTRL_WR,
    ACC_CONV,
    ACC_ADC,
    ACC_ID
  } acc_kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_HOLD
  } bus_state_t;

  localparam int unsigned RGN_CTRL = 0;
  localparam int unsigned RGN_CONV = 1;
  localparam int unsigned RGN_ADC  = 2;

endpackage

// File: rtl/ipm_decode.sv
module ipm_decode
  import ipm_pkg::*;
#(
  parameter int unsigned IO_ADDR_W = 6,
  parameter int unsigned SLOT_W    = 3
) (
  input  logic                 io_sel,
  input  logic                 id_sel,
  input  logic                 wr,
  input  logic [IO_ADDR_W-1:0] addr,
  output logic                 any_sel,
  output acc_kind_t            kind
);
  localparam int unsigned RGN_W = IO_ADDR_W - SLOT_W;

  logic [RGN_W-1:0] region;

  assign region  = addr[IO_ADDR_W-1:SLOT_W];
  assign any_sel = io_sel | id_sel;

  always_comb begin
    kind = ACC_NONE;
    if (io_sel) begin
      if (region == RGN_W'(RGN_CTRL))
        kind = wr ? ACC_CTRL_WR : ACC_CTRL_RD;
      else if (region == RGN_W'(RGN_CONV) && wr)
        kind = ACC_CONV;
      else if (region == RGN_W'(RGN_ADC) && !wr)
        kind = ACC_ADC;
    end else if (id_sel && !wr) begin
      kind = ACC_ID;
    end
  end
endmodule

// File: rtl/ipm_id_rom.sv
module ipm_id_rom #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_out
);
  always_comb begin
    case (idx)
      IDX_W'(0):  byte_out = 8'h49;
      IDX_W'(1):  byte_out = 8'h50;
      IDX_W'(2):  byte_out = 8'h41;
      IDX_W'(3):  byte_out = 8'h43;
      IDX_W'(4):  byte_out = 8'hA3;
      IDX_W'(5):  byte_out = 8'h32;
      IDX_W'(10): byte_out = 8'h0C;
      IDX_W'(11): byte_out = 8'h2E;
      default:    byte_out = 8'h00;
    endcase
  end
endmodule

// File: rtl/ipm_ctrl_reg.sv
module ipm_ctrl_reg #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TRIG_BIT = 15,
  parameter int unsigned MODE_LSB = 8,
  parameter int unsigned MODE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              trig_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [DATA_W-1:0] rd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      mode_q <= '0;
    end else if (we) begin
      trig_q <= wdata[TRIG_BIT];
      mode_q <= wdata[MODE_LSB +: MODE_W];
    end
  end

  always_comb begin
    rd_word                     = '0;
    rd_word[TRIG_BIT]           = trig_q;
    rd_word[MODE_LSB +: MODE_W] = mode_q;
  end

  // R2/R3: fields change only on a write strobe
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable({trig_q, mode_q}) |-> $past(we));
endmodule

// File: rtl/ipm_bus_slave.sv
module ipm_bus_slave
  import ipm_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned IO_ADDR_W   = 6,
  parameter int unsigned SLOT_W      = 3,
  parameter int unsigned ID_IDX_W    = 5,
  parameter int unsigned CTRL_WAITS  = 1,
  parameter int unsigned MODE_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_sel,
  input  logic                 id_sel,
  input  logic                 wr,
  input  logic [IO_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    adc_data,
  output logic [DATA_W-1:0]    rdata,
  output logic                 ack,
  output logic                 conv_pulse,
  output logic                 trig_ctl,
  output logic [MODE_W-1:0]    mode
);
  localparam int unsigned WCNT_W = (CTRL_WAITS < 2) ? 1 : $clog2(CTRL_WAITS);

  bus_state_t        state_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic              any_sel;
  acc_kind_t         kind;
  logic [7:0]        id_byte;
  logic [DATA_W-1:0] ctrl_word;
  logic              ctrl_we;

  ipm_decode #(.IO_ADDR_W(IO_ADDR_W), .SLOT_W(SLOT_W)) u_decode (
    .io_sel  (io_sel),
    .id_sel  (id_sel),
    .wr      (wr),
    .addr    (addr),
    .any_sel (any_sel),
    .kind    (kind)
  );

  ipm_id_rom #(.IDX_W(ID_IDX_W)) u_id_rom (
    .idx      (addr[ID_IDX_W-1:0]),
    .byte_out (id_byte)
  );

  ipm_ctrl_reg #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl_we),
    .wdata   (wdata),
    .trig_q  (trig_ctl),
    .mode_q  (mode),
    .rd_word (ctrl_word)
  );

  assign ctrl_we = (state_q == S_WAIT) && io_sel && (wcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      wcnt_q     <= '0;
      ack        <= 1'b0;
      conv_pulse <= 1'b0;
      rdata      <= '0;
    end else begin
      ack        <= 1'b0;
      conv_pulse <= 1'b0;
      rdata      <= '0;
      case (state_q)
        S_IDLE: begin
          if (any_sel) begin
            state_q <= S_HOLD;
            case (kind)
              ACC_CTRL_RD: begin
                ack   <= 1'b1;
                rdata <= ctrl_word;
              end
              ACC_CTRL_WR: begin
                wcnt_q  <= WCNT_W'(CTRL_WAITS - 1);
                state_q <= S_WAIT;
              end
              ACC_CONV: begin
                ack        <= 1'b1;
                conv_pulse <= 1'b1;
              end
              ACC_ADC: begin
                ack   <= 1'b1;
                rdata <= adc_data;
              end
              ACC_ID: begin
                ack   <= 1'b1;
                rdata <= {{(DATA_W-8){1'b0}}, id_byte};
              end
              default: ;
            endcase
          end
        end
        S_WAIT: begin
          if (!io_sel) begin
            state_q <= S_IDLE;
          end else if (wcnt_q == '0) begin
            ack     <= 1'b1;
            state_q <= S_HOLD;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        S_HOLD: begin
          if (!any_sel) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10: acknowledge lasts one cycle
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R10: acknowledge only follows a sampled select
  p_ack_needs_sel_r10: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(io_sel || id_sel));

  // R4: convert pulse only with the acknowledge of a write
  p_conv_with_ack_r4: assert property (@(posedge clk) disable iff (rst)
    conv_pulse |-> (ack && $past(wr) && $past(io_sel)));

  // R12: read data is quiet outside acknowledge
  p_rdata_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (rdata == '0));

  // R8: ID reads keep the upper lane at zero
  p_id_lane_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(id_sel && !io_sel)) |-> (rdata[DATA_W-1:8] == '0));

  // R9: ID writes never acknowledge
  p_id_write_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && id_sel && !io_sel && wr) |=> !ack);
endmodule

// File: tb/test_ipm_bus_slave.sv
module test_ipm_bus_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        io_sel, id_sel, wr;
  logic [5:0]  addr;
  logic [15:0] wdata, adc_data;
  logic [15:0] rdata;
  logic        ack, conv_pulse, trig_ctl;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_ctrl;

  ipm_bus_slave i_ipm_bus_slave (
    .clk(clk), .rst(rst), .io_sel(io_sel), .id_sel(id_sel), .wr(wr),
    .addr(addr), .wdata(wdata), .adc_data(adc_data), .rdata(rdata),
    .ack(ack), .conv_pulse(conv_pulse), .trig_ctl(trig_ctl), .mode(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_exp(input logic [4:0] i);
    logic [7:0] t [12] = '{8'h49, 8'h50, 8'h41, 8'h43, 8'hA3, 8'h32,
                           8'h00, 8'h00, 8'h00, 8'h00, 8'h0C, 8'h2E};
    return (i < 12) ? t[i] : 8'h00;
  endfunction

  // expected: does it ack, cycles to ack, data, conv
  task automatic expect_of(input bit io, input bit id, input bit w,
                           input logic [5:0] a, input logic [15:0] d,
                           input logic [15:0] adc,
                           output bit eack, output int ecyc,
                           output logic [15:0] edata, output bit econv,
                           output string tag);
    eack = 0; ecyc = 1; edata = 16'h0; econv = 0; tag = "R6";
    if (io) begin
      case (a[5:3])
        3'd0: begin
          eack = 1; tag = w ? "R3" : "R2";
          if (w) ecyc = 2; else edata = model_ctrl;
        end
        3'd1: begin tag = w ? "R4" : "R7"; eack = w; econv = w; end
        3'd2: begin tag = w ? "R7" : "R5"; eack = !w; if (!w) edata = adc; end
        default: tag = "R6";
      endcase
      if (id) tag = {tag, "/R11"};
    end else if (id) begin
      tag = w ? "R9" : "R8";
      eack = !w;
      if (!w) edata = {8'h00, id_exp(a[4:0])};
    end
  endtask

  task automatic access(input bit io, input bit id, input bit w,
                        input logic [5:0] a, input logic [15:0] d);
    bit eack, econv, got, cs, quiet;
    int ecyc, cyc;
    logic [15:0] edata, got_data, adc;
    string tag;
    @(negedge clk);
    adc = 16'($urandom);
    io_sel = io; id_sel = id; wr = w; addr = a; wdata = d; adc_data = adc;
    expect_of(io, id, w, a, d, adc, eack, ecyc, edata, econv, tag);
    cyc = 0; got = 0; cs = 0; quiet = 1; got_data = 16'h0;
    while (!got && cyc < 5) begin
      @(posedge clk); #1;
      cyc++;
      if (conv_pulse) cs = 1;
      if (ack) begin got = 1; got_data = rdata; end
      else if (rdata != 16'h0) quiet = 0;
    end
    adc_data = ~adc;
    check(got == eack, {tag, " ack"}, 32'(got), 32'(eack));
    if (eack && got) begin
      check(cyc == ecyc, {tag, " wait"}, 32'(cyc), 32'(ecyc));
      check(got_data == edata, {tag, " data"}, 32'(got_data), 32'(edata));
    end
    check(cs == econv, {tag, " conv"}, 32'(cs), 32'(econv));
    check(quiet, "R12 rdata idle", 32'(quiet), 32'd1);
    if (io && a[5:3] == 3'd0 && w && got)
      model_ctrl = {d[15], 5'b0, d[9:8], 8'h00};
    @(negedge clk);
    io_sel = 0; id_sel = 0;
    @(posedge clk); #1;
    check(!ack && !conv_pulse, "R10 single ack", {ack, conv_pulse}, 32'd0);
    check({trig_ctl, mode} == {model_ctrl[15], model_ctrl[9:8]},
          "R2 fields", {trig_ctl, mode}, {model_ctrl[15], model_ctrl[9:8]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_ctrl = 16'h0;
    rst = 1; io_sel = 0; id_sel = 0; wr = 0; addr = 0; wdata = 0; adc_data = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!ack && !conv_pulse && rdata == 0 && !trig_ctl && mode == 0,
          "R1 reset", {ack, conv_pulse, trig_ctl, mode, rdata}, 32'd0);
    @(negedge clk); rst = 0;

    // R2/R3: write each alias, read back through another
    for (int i = 0; i < 8; i++) begin
      access(1, 0, 1, 6'(i), 16'($urandom));
      access(1, 0, 0, 6'((i + 3) % 8), 16'h0);
    end
    access(1, 0, 1, 6'd5, 16'hFFFF);
    access(1, 0, 0, 6'd2, 16'h0);
    // R4: convert ignores data
    for (int i = 8; i < 16; i++) access(1, 0, 1, 6'(i), 16'h0000);
    access(1, 0, 0, 6'd0, 16'h0);
    // R5 ADC reads
    for (int i = 16; i < 24; i++) access(1, 0, 0, 6'(i), 16'h0);
    // R6 unused/reserved, both directions
    for (int i = 24; i < 64; i++) begin
      access(1, 0, 1, 6'(i), 16'h0000);
      access(1, 0, 0, 6'(i), 16'h0);
    end
    access(1, 0, 0, 6'd1, 16'h0);
    // R7 wrong direction
    access(1, 0, 0, 6'd9, 16'h0);
    access(1, 0, 1, 6'd17, 16'h0000);
    access(1, 0, 0, 6'd3, 16'h0);
    // R8 ID image, with alias bit set
    for (int i = 0; i < 64; i++) access(0, 1, 0, 6'(i), 16'h0);
    // R9 ID writes
    access(0, 1, 1, 6'd0, 16'h0000);
    access(1, 0, 0, 6'd0, 16'h0);
    // R11 both selects
    access(1, 1, 0, 6'd18, 16'h0);
    access(1, 1, 1, 6'd2, 16'h8200);
    access(1, 1, 0, 6'd4, 16'h0);
    // random mix
    for (int n = 0; n < 600; n++)
      access(1'($urandom), 1'($urandom), 1'($urandom), 6'($urandom),
             16'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule